// File: doc/BRIEF.md
# Synthesizer Register Slave on I2C

This block is a serial-bus target that programs the settings of a frequency synthesizer: a 15-bit loop divider ratio, a control group (charge-pump current select, three test bits, a two-bit reference-divider select and an output-amplifier disable), and four band-switch outputs. A host controller addresses it on a two-wire I2C bus. A write carries up to four data bytes. A read returns one status byte. SCL and SDA are sampled in the system clock domain, and the block drives SDA open-drain through an output enable. Arbitration between several masters, clock stretching and the converter that produces the three-bit level code are outside this block. That code arrives on an input.

The 7-bit target address is a fixed prefix `11000` followed by two strap inputs. Within a write, the most significant bit of the first data byte selects its meaning. A 0 makes it the upper divider byte, which is then followed by the lower divider byte, the control byte and the band byte. A 1 makes it the control byte, which is then followed by the band byte. The host can therefore update only the control and band settings without sending the divider. The divider register changes as a whole, and only after the lower divider byte has been acknowledged.

The bus state machine has these states: `ST_IDLE`, `ST_ADDR` (shift the address), `ST_ADDR_ACK`, `ST_WR_DATA`, `ST_WR_ACK`, `ST_RD_DATA`, `ST_RD_ACK` and `ST_HOLD` (ignore the bus until the next start or stop). It has these transitions:
- Any state goes to `ST_ADDR` on a start condition and to `ST_IDLE` on a stop condition.
- `ST_ADDR` goes to `ST_ADDR_ACK` on a matching address, or to `ST_HOLD` on a mismatch. Either happens at the falling SCL edge after the eighth bit.
- `ST_ADDR_ACK` goes to `ST_WR_DATA` or `ST_RD_DATA`, depending on the direction bit.
- `ST_WR_DATA` goes to `ST_WR_ACK` after eight bits.
- `ST_WR_ACK` goes back to `ST_WR_DATA`, and the byte is committed at that point.
- `ST_RD_DATA` goes to `ST_RD_ACK` after eight bits.
- `ST_RD_ACK` goes to `ST_RD_DATA` if the master acknowledges, or to `ST_HOLD` if it does not.

Top module: `synth_i2c_regs`

## Requirements
- R1: After reset the outputs are: divider 0, `cp_hi`=1, `test_bits`=000, `ref_sel`=00, `amp_off`=0, `band_sw`=1111, and SDA is released.
- R2: The block acknowledges only the address byte `{11000, strap[1], strap[0], rw}`, by pulling SDA low during the ninth SCL pulse. After a mismatched address it drives nothing and changes no setting until the next start or stop.
- R3: A write whose first data byte has MSB 0 loads `div_ratio = {byte1[6:0], byte2}`. The next byte loads the control group and the byte after that loads the band switches.
- R4: A write whose first data byte has MSB 1 treats it as the control byte, with bit6=CP, bits5:3=T2..T0, bit2=RSA (`ref_sel[1]`), bit1=RSB (`ref_sel[0]`) and bit0=OS (`amp_off`). The following byte is the band byte. The divider is left unchanged.
- R5: A write that stops after the upper divider byte leaves `div_ratio` unchanged.
- R6: The band byte drives `band_sw` from its low four bits. Its upper four bits have no effect.
- R7: Data bytes after the band byte are acknowledged, but they change no setting.
- R8: A read returns `{POR, lock_i, acps_i, 1, 1, adc_code[2:0]}`, most significant bit first.
- R9: POR reads 1 after reset and reads 0 once a status byte has been read out.
- R10: When the master does not acknowledge a status byte, SDA stays released for every later clock until a stop or start.
- R11: Every data byte of an addressed write is acknowledged in its ninth SCL pulse.
- R12: `sda_oe` changes only while the sampled SCL is low. The one exception is the cycle after a start or stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap | input | 2 | Hardware address bits |
| adc_code | input | 3 | Level code reported in the status byte |
| lock_i | input | 1 | Loop-lock flag reported in the status byte |
| acps_i | input | 1 | Automatic pump-current flag reported in the status byte |
| div_ratio | output | 15 | Loop divider ratio |
| cp_hi | output | 1 | High charge-pump current select |
| test_bits | output | 3 | Test mode bits |
| ref_sel | output | 2 | Reference divider select {RSA,RSB} |
| amp_off | output | 1 | 1 disables the output amplifier |
| band_sw | output | 4 | Band switches, 0 = switch on |

## Verification
A wrong byte slot shows up at the setting outputs straight after the acknowledge of the misrouted byte: the divider moves on a control-first write, the band takes the control value, or the divider changes after a single byte. A wrong bus state or bit count shows up within one byte as a missing or misplaced acknowledge, or as a status byte shifted by one bit. A POR flag that is not cleared is visible on the second read. The directed write scenarios read every setting back immediately after each stop, and the read scenarios sample the line at the middle of every high phase of SCL.

// File: rtl/synth_i2c_pkg.sv
package synth_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_HOLD
    } bus_state_e;

    typedef enum logic [2:0] {
        SL_LEAD,
        SL_DIV_LO,
        SL_CTRL,
        SL_BAND,
        SL_DONE
    } byte_slot_e;

    localparam logic [4:0] ADDR_PREFIX = 5'b11000;

    typedef struct packed {
        logic       cp;
        logic [2:0] test;
        logic [1:0] rs;
        logic       amp_off;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{cp: 1'b1, test: 3'b000, rs: 2'b00, amp_off: 1'b0};

endpackage

// File: rtl/sic_line_cond.sv
module sic_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_sync;
    logic [TOP:0] sda_sync;
    logic         scl_p;
    logic         sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[TOP-1:0], scl_in};
            sda_sync <= {sda_sync[TOP-1:0], sda_in};
            scl_p    <= scl_sync[TOP];
            sda_p    <= sda_sync[TOP];
        end
    end

    assign scl_q     = scl_sync[TOP];
    assign sda_q     = sda_sync[TOP];
    assign scl_rise  = scl_q & ~scl_p;
    assign scl_fall  = ~scl_q & scl_p;
    assign start_det = scl_q & scl_p & sda_p & ~sda_q;
    assign stop_det  = scl_q & scl_p & ~sda_p & sda_q;

endmodule

// File: rtl/sic_regbank.sv
module sic_regbank
    import synth_i2c_pkg::*;
#(
    parameter int DIV_W  = 15,
    parameter int BAND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic              wr_pulse,
    input  logic [7:0]        wr_byte,
    output logic [DIV_W-1:0]  div_q,
    output ctrl_t             ctrl_q,
    output logic [BAND_W-1:0] band_q
);
    localparam int HI_W = DIV_W - 8;

    byte_slot_e      slot_q, slot_d;
    logic [HI_W-1:0] hi_q;
    logic            take_hi, take_lo, take_ctrl, take_band;

    always_comb begin
        slot_d    = slot_q;
        take_hi   = 1'b0;
        take_lo   = 1'b0;
        take_ctrl = 1'b0;
        take_band = 1'b0;
        unique case (slot_q)
            SL_LEAD: begin
                if (wr_byte[7]) begin
                    take_ctrl = 1'b1;
                    slot_d    = SL_BAND;
                end else begin
                    take_hi = 1'b1;
                    slot_d  = SL_DIV_LO;
                end
            end
            SL_DIV_LO: begin
                take_lo = 1'b1;
                slot_d  = SL_CTRL;
            end
            SL_CTRL: begin
                take_ctrl = 1'b1;
                slot_d    = SL_BAND;
            end
            SL_BAND: begin
                take_band = 1'b1;
                slot_d    = SL_DONE;
            end
            SL_DONE: slot_d = SL_DONE;
            default: slot_d = SL_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= SL_LEAD;
            hi_q   <= '0;
            div_q  <= '0;
            ctrl_q <= CTRL_RESET;
            band_q <= '1;
        end else if (txn_start) begin
            slot_q <= SL_LEAD;
        end else if (wr_pulse) begin
            slot_q <= slot_d;
            if (take_hi)   hi_q   <= wr_byte[HI_W-1:0];
            if (take_lo)   div_q  <= {hi_q, wr_byte};
            if (take_ctrl) ctrl_q <= ctrl_t'(wr_byte[6:0]);
            if (take_band) band_q <= wr_byte[BAND_W-1:0];
        end
    end

    // R5: divider moves only on the lower-divider byte commit
    a_r5_div_atomic: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_q) |-> $past(wr_pulse && !txn_start && slot_q == SL_DIV_LO));

    // R7: once the band byte is in, extra bytes touch nothing
    a_r7_extra_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && !txn_start && slot_q == SL_DONE) |=> $stable({div_q, ctrl_q, band_q}));

endmodule

// File: rtl/synth_i2c_regs.sv
module synth_i2c_regs
    import synth_i2c_pkg::*;
#(
    parameter int DIV_W       = 15,
    parameter int BAND_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [1:0]        strap,
    input  logic [2:0]        adc_code,
    input  logic              lock_i,
    input  logic              acps_i,
    output logic [DIV_W-1:0]  div_ratio,
    output logic              cp_hi,
    output logic [2:0]        test_bits,
    output logic [1:0]        ref_sel,
    output logic              amp_off,
    output logic [BAND_W-1:0] band_sw
);
    localparam logic [3:0] BITS_PER_BYTE = 4'd8;
    localparam logic [3:0] LAST_TX_BIT   = 4'd7;

    logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;

    sic_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
        .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    bus_state_e state_q, state_d;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;
    logic [3:0] cnt_q;
    logic       mack_q;
    logic       por_q;
    logic       addr_hit;
    logic       wr_pulse;
    logic       txn_start;
    logic [7:0] status_byte;

    assign addr_hit    = (rx_sh[7:1] == {ADDR_PREFIX, strap});
    assign status_byte = {por_q, lock_i, acps_i, 2'b11, adc_code};

    // next state
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (scl_fall && cnt_q == BITS_PER_BYTE)
                                 state_d = addr_hit ? ST_ADDR_ACK : ST_HOLD;
                ST_ADDR_ACK: if (scl_fall)
                                 state_d = rx_sh[0] ? ST_RD_DATA : ST_WR_DATA;
                ST_WR_DATA:  if (scl_fall && cnt_q == BITS_PER_BYTE)
                                 state_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_d = ST_WR_DATA;
                ST_RD_DATA:  if (scl_fall && cnt_q == LAST_TX_BIT)
                                 state_d = ST_RD_ACK;
                ST_RD_ACK: begin
                    if (scl_rise && sda_q)        state_d = ST_HOLD;
                    else if (scl_fall && mack_q)  state_d = ST_RD_DATA;
                end
                ST_HOLD:     state_d = ST_HOLD;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // shift, count and flag datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh  <= '0;
            tx_sh  <= '1;
            cnt_q  <= '0;
            mack_q <= 1'b0;
            por_q  <= 1'b1;
        end else begin
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if ((state_q == ST_ADDR || state_q == ST_WR_DATA) &&
                         scl_rise && cnt_q < BITS_PER_BYTE) begin
                rx_sh <= {rx_sh[6:0], sda_q};
                cnt_q <= cnt_q + 4'd1;
            end else if (state_q == ST_RD_DATA && scl_fall) begin
                tx_sh <= {tx_sh[6:0], 1'b1};
                cnt_q <= cnt_q + 4'd1;
            end
            if (state_d == ST_RD_DATA && state_q != ST_RD_DATA)
                tx_sh <= status_byte;
            if (state_d == ST_RD_ACK && state_q != ST_RD_ACK)
                mack_q <= 1'b0;
            if (state_q == ST_RD_ACK && scl_rise) begin
                mack_q <= ~sda_q;
                por_q  <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe    = 1'b0;
        wr_pulse  = 1'b0;
        txn_start = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK: begin
                sda_oe    = 1'b1;
                txn_start = scl_fall;
            end
            ST_WR_ACK: begin
                sda_oe   = 1'b1;
                wr_pulse = scl_fall & ~start_det & ~stop_det;
            end
            ST_RD_DATA: sda_oe = ~tx_sh[7];
            default:    sda_oe = 1'b0;
        endcase
    end

    ctrl_t ctrl_w;

    sic_regbank #(.DIV_W(DIV_W), .BAND_W(BAND_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .wr_pulse(wr_pulse),
        .wr_byte(rx_sh), .div_q(div_ratio), .ctrl_q(ctrl_w), .band_q(band_sw)
    );

    assign cp_hi     = ctrl_w.cp;
    assign test_bits = ctrl_w.test;
    assign ref_sel   = ctrl_w.rs;
    assign amp_off   = ctrl_w.amp_off;

    // R12: the data line drive moves only while the clock line is low
    a_r12_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(start_det || stop_det)) |-> !scl_q);

    // R2: a mismatched address is never acknowledged
    a_r2_no_ack_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR && scl_fall && cnt_q == BITS_PER_BYTE && !addr_hit &&
         !start_det && !stop_det) |=> !sda_oe);

    // R9: the status flag drops after a byte has been read out
    a_r9_por_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_ACK && scl_rise) |=> !por_q);

    // R11: bit counter stays within one byte
    a_r11_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= BITS_PER_BYTE);

endmodule

// File: tb/tb_synth_i2c_regs.sv
module tb_synth_i2c_regs;
    localparam int H = 20;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        scl_m, sda_m;
    logic        sda_oe;
    logic [1:0]  strap;
    logic [2:0]  adc_code;
    logic        lock_i, acps_i;
    logic [14:0] div_ratio;
    logic        cp_hi, amp_off;
    logic [2:0]  test_bits;
    logic [1:0]  ref_sel;
    logic [3:0]  band_sw;
    wire         sda_line = sda_m & ~sda_oe;

    int n_cmp = 0;
    int n_bad = 0;

    synth_i2c_regs dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap(strap), .adc_code(adc_code), .lock_i(lock_i), .acps_i(acps_i),
        .div_ratio(div_ratio), .cp_hi(cp_hi), .test_bits(test_bits), .ref_sel(ref_sel),
        .amp_off(amp_off), .band_sw(band_sw)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wt(H);
        sda_m = 1'b0; wt(H);
        scl_m = 1'b0; wt(H/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(H/2);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, output logic low_seen);
        low_seen = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(H/2);
            scl_m = 1'b1; wt(H/2);
            if (b[i] && !sda_line) low_seen = 1'b1;
            wt(H/2);
            scl_m = 1'b0; wt(H/2);
        end
        sda_m = 1'b1; wt(H/2);
        scl_m = 1'b1; wt(H/2);
        ack = ~sda_line;
        wt(H/2);
        scl_m = 1'b0; wt(H/2);
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(H/2);
            scl_m = 1'b1; wt(H/2);
            d[i] = sda_line;
            wt(H/2);
            scl_m = 1'b0;
        end
        wt(H/2);
        sda_m = ~give_ack; wt(H/2);
        scl_m = 1'b1; wt(H);
        scl_m = 1'b0; wt(H/2);
        sda_m = 1'b1;
    endtask

    function automatic logic [31:0] ctrl_view();
        return {25'd0, cp_hi, test_bits, ref_sel, amp_off};
    endfunction

    task automatic t_reset();
        chk("R1 divider", div_ratio, 0);
        chk("R1 control", ctrl_view(), 32'h40);
        chk("R1 band", band_sw, 4'hF);
        chk("R1 sda released", sda_oe, 0);
    endtask

    task automatic t_full_write();
        logic a, l;
        bus_start();
        send_byte(8'hC4, a, l); chk("R2 address ack", a, 1);
        send_byte(8'h2A, a, l); chk("R11 ack div hi", a, 1);
        send_byte(8'h5C, a, l); chk("R11 ack div lo", a, 1);
        send_byte(8'h9D, a, l); chk("R11 ack control", a, 1);
        send_byte(8'hA5, a, l); chk("R11 ack band", a, 1);
        send_byte(8'h03, a, l); chk("R7 extra byte ack", a, 1);
        bus_stop();
        chk("R3 divider", div_ratio, 32'h2A5C);
        chk("R3 control", ctrl_view(), 32'h1D);
        chk("R6 band low nibble", band_sw, 4'h5);
        chk("R7 extra byte ignored", {div_ratio, band_sw}, {15'h2A5C, 4'h5});
    endtask

    task automatic t_ctrl_first();
        logic a, l;
        bus_start();
        send_byte(8'hC4, a, l);
        send_byte(8'hE0, a, l); chk("R4 ack control", a, 1);
        send_byte(8'hFC, a, l);
        bus_stop();
        chk("R4 control", ctrl_view(), 32'h60);
        chk("R4 band", band_sw, 4'hC);
        chk("R4 divider kept", div_ratio, 32'h2A5C);
    endtask

    task automatic t_div_partial();
        logic a, l;
        bus_start();
        send_byte(8'hC4, a, l);
        send_byte(8'h11, a, l);
        bus_stop();
        chk("R5 divider unchanged", div_ratio, 32'h2A5C);
        bus_start();
        send_byte(8'hC4, a, l);
        send_byte(8'h11, a, l);
        send_byte(8'h22, a, l);
        bus_stop();
        chk("R3 divider second", div_ratio, 32'h1122);
        chk("R3 control kept", ctrl_view(), 32'h60);
    endtask

    task automatic t_wrong_addr();
        logic a, l;
        bus_start();
        send_byte(8'hC2, a, l); chk("R2 mismatch no ack", a, 0);
        send_byte(8'h00, a, l); chk("R2 data not acked", a, 0);
        send_byte(8'h33, a, l);
        bus_stop();
        chk("R2 divider unchanged", div_ratio, 32'h1122);
    endtask

    task automatic t_read();
        logic a, l;
        logic [7:0] d;
        lock_i = 1'b1; acps_i = 1'b0; adc_code = 3'd5;
        bus_start();
        send_byte(8'hC5, a, l); chk("R2 read address ack", a, 1);
        recv_byte(d, 1'b0);
        chk("R8 status first", d, 8'hDD);
        send_byte(8'hFF, a, l);
        chk("R10 released after nack", {a, l}, 0);
        bus_stop();
        lock_i = 1'b0; acps_i = 1'b1; adc_code = 3'd2;
        bus_start();
        send_byte(8'hC5, a, l);
        recv_byte(d, 1'b1);
        chk("R9 por cleared", d, 8'h3A);
        recv_byte(d, 1'b0);
        chk("R8 status repeat", d, 8'h3A);
        bus_stop();
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; strap = 2'b10;
        adc_code = 3'd0; lock_i = 1'b0; acps_i = 1'b0;
        wt(5);
        rst_n = 1'b1;
        wt(5);
        t_reset();
        t_full_write();
        t_ctrl_first();
        t_div_partial();
        t_wrong_addr();
        t_read();
        finish_run();
    end

endmodule